// File: doc/BRIEF.md
# Shared-Adder Add/Subtract Unit with Condition Flags

This block is a purely combinational two's-complement adder/subtractor of parameterizable width (32 bits by default). A single ripple chain of full-adder cells serves both operations. In subtract mode the block inverts operand B bit by bit and drives the chain's carry-in high, so the chain produces A minus B without a second adder.

Alongside the result, the block produces four condition flags: zero, negative, carry-out and signed overflow. From those flags it derives ten comparison predicates, six signed and four unsigned. The predicates carry comparison meaning when the unit is subtracting, which is how a datapath uses it to compare two values. All outputs follow the inputs within the same cycle, and there is no register in the block.

Top module: `addsub_flags`

## Requirements
- R1: With sub_i = 0, res_o equals (a_i + b_i) modulo 2^WIDTH.
- R2: With sub_i = 1, res_o equals (a_i - b_i) modulo 2^WIDTH, formed as a_i + ~b_i + 1 on the shared chain.
- R3: zero_o is 1 exactly when every bit of res_o is 0.
- R4: neg_o equals the top bit of res_o.
- R5: carry_o is the carry out of the top column: when adding it is 1 iff a_i + b_i >= 2^WIDTH as unsigned values, and when subtracting it is 1 iff a_i >= b_i as unsigned values.
- R6: ovf_o is 1 exactly when the signed result of the selected operation does not fit in WIDTH bits.
- R7: cmp_o[0] (equal) is zero_o and cmp_o[1] (not equal) is its complement.
- R8: With sub_i = 1, the signed predicates match signed comparison of a_i against b_i: cmp_o[2] less, cmp_o[3] less-or-equal, cmp_o[4] greater-or-equal, cmp_o[5] greater. Exactly one of less, equal and greater is set.
- R9: With sub_i = 1, the unsigned predicates match unsigned comparison of a_i against b_i: cmp_o[6] less, cmp_o[7] less-or-equal, cmp_o[8] greater-or-equal, cmp_o[9] greater.
- R10: With all inputs at zero, res_o is 0, zero_o is 1 and the other flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| sub_i | input | 1 | 1 selects a_i - b_i, 0 selects a_i + b_i |
| res_o | output | WIDTH | Sum or difference |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Top bit of the result |
| carry_o | output | 1 | Carry out of the top column |
| ovf_o | output | 1 | Signed overflow |
| cmp_o | output | 10 | Comparison predicates, bit positions as in R7 to R9 |

## Verification
An 8-bit instance receives every operand pair in both modes, which gives 131072 vectors. Pairs such as all-ones plus one drive a carry through every column. Pairs that straddle the sign boundary, such as 0x7F plus 1 and 0x80 minus 1, separate the overflow rule from the carry rule. In subtract mode, equal operands, operands that differ only in the sign bit, and operands on either side of the signed and unsigned midpoints show whether each predicate reads the right flags. A ripple break at any position leaves some of these sums wrong.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef struct packed {
    logic zero;
    logic neg;
    logic carry;
    logic ovf;
  } cond_flags_t;

  localparam int unsigned CMP_W   = 10;
  localparam int unsigned CMP_EQ  = 0;
  localparam int unsigned CMP_NE  = 1;
  localparam int unsigned CMP_LT  = 2;
  localparam int unsigned CMP_LE  = 3;
  localparam int unsigned CMP_GE  = 4;
  localparam int unsigned CMP_GT  = 5;
  localparam int unsigned CMP_LTU = 6;
  localparam int unsigned CMP_LEU = 7;
  localparam int unsigned CMP_GEU = 8;
  localparam int unsigned CMP_GTU = 9;
endpackage

// File: rtl/full_add_cell.sv
module full_add_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic ci_i,
  output logic s_o,
  output logic co_o
);
  assign s_o  = a_i ^ b_i ^ ci_i;
  assign co_o = (a_i & b_i) | (a_i & ci_i) | (b_i & ci_i);
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             ci_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             co_o,
  output logic             c_msb_o
);
  logic [WIDTH:0] cy;

  assign cy[0] = ci_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_col
    full_add_cell u_fa (
      .a_i  (a_i[i]),
      .b_i  (b_i[i]),
      .ci_i (cy[i]),
      .s_o  (sum_o[i]),
      .co_o (cy[i+1])
    );
  end

  assign co_o    = cy[WIDTH];
  assign c_msb_o = cy[WIDTH-1];

  // R1/R2: ripple result against a behavioural wide sum
  always_comb begin
    if (!$isunknown({a_i, b_i, ci_i})) begin
      a_r1_chain_sum: assert ({co_o, sum_o} ==
                              ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, ci_i}))
        else $error("ripple chain sum mismatch");
    end
  end
endmodule

// File: rtl/flag_unit.sv
module flag_unit
  import addsub_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] res_i,
  input  logic             co_i,
  input  logic             c_msb_i,
  input  logic             a_msb_i,
  input  logic             bx_msb_i,
  output cond_flags_t      flags_o
);
  assign flags_o.zero  = ~|res_i;
  assign flags_o.neg   = res_i[WIDTH-1];
  assign flags_o.carry = co_i;
  assign flags_o.ovf   = co_i ^ c_msb_i;

  // R6: carry-based overflow must agree with the operand sign rule
  always_comb begin
    if (!$isunknown({res_i, co_i, c_msb_i, a_msb_i, bx_msb_i})) begin
      a_r6_ovf_sign_rule: assert (flags_o.ovf ==
                                  ((a_msb_i == bx_msb_i) && (res_i[WIDTH-1] != a_msb_i)))
        else $error("overflow disagrees with sign rule");
    end
  end
endmodule

// File: rtl/cmp_decode.sv
module cmp_decode
  import addsub_pkg::*;
(
  input  cond_flags_t      flags_i,
  output logic [CMP_W-1:0] cmp_o
);
  logic slt, ule;

  assign slt = flags_i.neg ^ flags_i.ovf;
  assign ule = ~flags_i.carry | flags_i.zero;

  always_comb begin
    cmp_o          = '0;
    cmp_o[CMP_EQ]  = flags_i.zero;
    cmp_o[CMP_NE]  = ~flags_i.zero;
    cmp_o[CMP_LT]  = slt;
    cmp_o[CMP_LE]  = flags_i.zero | slt;
    cmp_o[CMP_GE]  = ~slt;
    cmp_o[CMP_GT]  = ~(flags_i.zero | slt);
    cmp_o[CMP_LTU] = ~flags_i.carry;
    cmp_o[CMP_LEU] = ule;
    cmp_o[CMP_GEU] = flags_i.carry;
    cmp_o[CMP_GTU] = ~ule;
  end
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
  import addsub_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] res_o,
  output logic             zero_o,
  output logic             neg_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic [9:0]       cmp_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic             co, c_msb;
  cond_flags_t      flags;

  // subtract: invert B and inject carry-in on the same chain
  assign b_eff = b_i ^ {WIDTH{sub_i}};

  ripple_chain #(.WIDTH(WIDTH)) u_chain (
    .a_i     (a_i),
    .b_i     (b_eff),
    .ci_i    (sub_i),
    .sum_o   (res_o),
    .co_o    (co),
    .c_msb_o (c_msb)
  );

  flag_unit #(.WIDTH(WIDTH)) u_flags (
    .res_i    (res_o),
    .co_i     (co),
    .c_msb_i  (c_msb),
    .a_msb_i  (a_i[MSB]),
    .bx_msb_i (b_eff[MSB]),
    .flags_o  (flags)
  );

  cmp_decode u_cmp (
    .flags_i (flags),
    .cmp_o   (cmp_o)
  );

  assign zero_o  = flags.zero;
  assign neg_o   = flags.neg;
  assign carry_o = flags.carry;
  assign ovf_o   = flags.ovf;

  always_comb begin
    if (!$isunknown({a_i, b_i, sub_i}) && sub_i) begin
      a_r3_zero_equal: assert (zero_o == (a_i == b_i))
        else $error("zero flag disagrees with operand equality");
      a_r8_signed_lt: assert (cmp_o[CMP_LT] == ($signed(a_i) < $signed(b_i)))
        else $error("signed less-than mismatch");
      a_r8_trichotomy: assert ($countones({cmp_o[CMP_LT], cmp_o[CMP_EQ], cmp_o[CMP_GT]}) == 1)
        else $error("signed ordering not exclusive");
      a_r9_unsigned_lt: assert (cmp_o[CMP_LTU] == (a_i < b_i))
        else $error("unsigned less-than mismatch");
      a_r5_borrow: assert (carry_o == (a_i >= b_i))
        else $error("carry disagrees with unsigned order");
    end
  end
endmodule

// File: tb/sim_addsub_flags.sv
module sim_addsub_flags;
  localparam int W = 8;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         sub;
    logic [W-1:0] res;
    logic         z, n, c, v;
    logic [9:0]   cmp;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic         sub_i = 1'b0;
  logic [W-1:0] res_o;
  logic         zero_o, neg_o, carry_o, ovf_o;
  logic [9:0]   cmp_o;

  int n_chk = 0;
  int n_fail = 0;
  bit drv_done = 1'b0;
  bit finished = 1'b0;
  item_t q[$];

  always #2 clk = ~clk;

  addsub_flags #(.WIDTH(W)) u0 (
    .a_i(a_i), .b_i(b_i), .sub_i(sub_i),
    .res_o(res_o), .zero_o(zero_o), .neg_o(neg_o),
    .carry_o(carry_o), .ovf_o(ovf_o), .cmp_o(cmp_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s a=%0h b=%0h sub=%0b actual=%0h expected=%0h",
               tag, a_i, b_i, sub_i, act, exp);
    end
  endtask

  function automatic item_t model(input logic [W-1:0] a, input logic [W-1:0] b, input logic sub);
    item_t it;
    int ua, ub, sa, sb, ur, sr;
    ua = int'(a); ub = int'(b);
    sa = (ua >= 128) ? ua - 256 : ua;
    sb = (ub >= 128) ? ub - 256 : ub;
    ur = sub ? ua - ub : ua + ub;
    sr = sub ? sa - sb : sa + sb;
    it.a = a; it.b = b; it.sub = sub;
    it.res = W'((ur + 512) % 256);
    it.z = (it.res == 0);
    it.n = it.res[W-1];
    it.c = sub ? (ua >= ub) : (ur >= 256);
    it.v = (sr > 127) || (sr < -128);
    it.cmp[0] = it.z;
    it.cmp[1] = !it.z;
    it.cmp[2] = sa < sb;
    it.cmp[3] = sa <= sb;
    it.cmp[4] = sa >= sb;
    it.cmp[5] = sa > sb;
    it.cmp[6] = ua < ub;
    it.cmp[7] = ua <= ub;
    it.cmp[8] = ua >= ub;
    it.cmp[9] = ua > ub;
    return it;
  endfunction

  // driver
  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: zero inputs during reset
    chk(res_o == 0, "R10 res", int'(res_o), 0);
    chk(zero_o == 1'b1, "R10 zero", int'(zero_o), 1);
    chk({neg_o, carry_o, ovf_o} == 3'b000, "R10 nco", int'({neg_o, carry_o, ovf_o}), 0);
    rst_ni = 1'b1;
    for (int s = 0; s < 2; s++) begin
      for (int x = 0; x < 256; x++) begin
        for (int y = 0; y < 256; y++) begin
          @(posedge clk);
          a_i   = W'(x);
          b_i   = W'(y);
          sub_i = s[0];
          q.push_back(model(W'(x), W'(y), s[0]));
        end
      end
    end
    repeat (3) @(posedge clk);
    drv_done = 1'b1;
  end

  // monitor
  initial begin
    item_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(res_o == e.res, e.sub ? "R2 res" : "R1 res", int'(res_o), int'(e.res));
        chk(zero_o == e.z, "R3 zero", int'(zero_o), int'(e.z));
        chk(neg_o == e.n, "R4 neg", int'(neg_o), int'(e.n));
        chk(carry_o == e.c, "R5 carry", int'(carry_o), int'(e.c));
        chk(ovf_o == e.v, "R6 ovf", int'(ovf_o), int'(e.v));
        chk(cmp_o[1:0] == e.cmp[1:0], "R7 eq/ne", int'(cmp_o[1:0]), int'(e.cmp[1:0]));
        if (e.sub) begin
          chk(cmp_o[5:2] == e.cmp[5:2], "R8 signed", int'(cmp_o[5:2]), int'(e.cmp[5:2]));
          chk(cmp_o[9:6] == e.cmp[9:6], "R9 unsigned", int'(cmp_o[9:6]), int'(e.cmp[9:6]));
        end
      end
    end
  end

  initial begin
    wait (drv_done);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule